// File: doc/BRIEF.md
# DS3 Error Counter Bank

This block gathers per-frame error indications from a DS3 framer and keeps four performance counts: framing/multiframe bit errors, P-bit parity disagreements, C-bit parity votes and far-end block error frames. The framer presents its per-frame observations alongside a one-cycle frame strobe. The F-bit and M-bit error strobes stand apart and may arrive in any cycle.

Each count lives in a running register. A one-cycle latch pulse copies all four running counts into their hold registers at the same edge and restarts the running counts. The hold registers then stay fixed for software until the next pulse. A mode input sets what a running count does at its ceiling: it either stays there or wraps to zero. A second mode input enables the two counters that only have meaning when the C-bit parity application is in use.

Top module: `ds3_pm_bank`

## Requirements
- R1: The 12-bit F/M count adds one for each of `fbit_err` and `mbit_err` that is high in a cycle. It adds two when both are high, whether or not `frame_stb` is high.
- R2: On a cycle with `frame_stb` high, the 14-bit P count adds one if either bit of `p_rx` differs from `p_ref`. It adds at most one per frame.
- R3: On a cycle with `frame_stb` and `cbit_mode` high, the 14-bit C-parity count adds one when two or three bits of `cp_rx` differ from `cp_ref`. Zero or one differing bit adds nothing.
- R4: On a cycle with `frame_stb` and `cbit_mode` high, the 14-bit FEBE count adds exactly one when any bit of `febe_rx` is 0. An all-ones `febe_rx` adds nothing.
- R5: With `cbit_mode` low, the C-parity and FEBE counts ignore `cp_rx`, `cp_ref` and `febe_rx`.
- R6: At the rising edge where `pm_latch` is high, every hold output takes the running count it had before that edge, and the running count restarts. The new hold value is visible after that edge.
- R7: An increment that arrives in the same cycle as `pm_latch` belongs to the new interval, so the running count restarts at that increment (1, or 2 for a double F/M error).
- R8: The hold outputs do not change between latch pulses, whatever events arrive.
- R9: With `sat_mode` high, a running count that would pass its all-ones maximum stays at the maximum.
- R10: With `sat_mode` low, a running count that would pass its maximum wraps modulo 2^width. For example, 4094 plus a double F/M error gives 0.
- R11: While `rst_n` is low, all running counts and hold outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sat_mode | input | 1 | 1: counts saturate at the maximum; 0: counts wrap |
| cbit_mode | input | 1 | 1: C-bit parity application, which enables the C-parity and FEBE counts |
| pm_latch | input | 1 | One-cycle pulse that latches running counts into the holds and restarts them |
| frame_stb | input | 1 | Marks the cycle that carries one frame's P, C-parity and FEBE bits |
| fbit_err | input | 1 | F-bit error strobe |
| mbit_err | input | 1 | M-bit error strobe |
| p_rx | input | 2 | Received P bits of the frame |
| p_ref | input | 1 | Parity computed over the previous frame |
| cp_rx | input | 3 | Received C-bit parity bits |
| cp_ref | input | 1 | Expected C-bit parity value |
| febe_rx | input | 3 | Received FEBE bits; 0 flags an error |
| hold_fm | output | 12 | Latched F/M error count |
| hold_p | output | 14 | Latched P-bit error count |
| hold_cp | output | 14 | Latched C-bit parity error count |
| hold_febe | output | 14 | Latched FEBE frame count |

## Verification
An event sampled at a rising edge reaches the running count at that edge. The count becomes visible on the holds only at the edge where a later `pm_latch` is sampled, one register stage on. The bench drives its inputs on falling edges. For each latch it pushes the expected hold values into a queue, and the monitor pops and compares them at the falling edge that follows the latch edge. Between latches, the holds are compared against the last expected set at falling edges, which shows that events arriving meanwhile leave them unchanged.

// File: rtl/ds3_pm_pkg.sv
package ds3_pm_pkg;

  localparam int unsigned NUM_P  = 2;
  localparam int unsigned NUM_CP = 3;
  localparam int unsigned NUM_FB = 3;
  localparam int unsigned ARITH_W = 16;

  // Any P bit that disagrees with the previous frame's parity.
  function automatic logic p_mismatch(input logic [NUM_P-1:0] rx, input logic ref_bit);
    return |(rx ^ {NUM_P{ref_bit}});
  endfunction

  // At least two of the C-parity bits disagree.
  function automatic logic cp_vote(input logic [NUM_CP-1:0] rx, input logic ref_bit);
    logic [NUM_CP-1:0] d;
    int unsigned n;
    d = rx ^ {NUM_CP{ref_bit}};
    n = 0;
    for (int i = 0; i < NUM_CP; i++) n += d[i];
    return n >= 2;
  endfunction

  // Any FEBE bit at zero.
  function automatic logic febe_hit(input logic [NUM_FB-1:0] rx);
    return ~&rx;
  endfunction

  // Next running value: saturate or wrap at 2^w - 1.
  function automatic logic [ARITH_W-1:0] pm_bump(input logic [ARITH_W-1:0] cur,
                                                 input logic [1:0] inc,
                                                 input int unsigned w,
                                                 input logic sat);
    logic [ARITH_W:0] sum;
    logic [ARITH_W:0] lim;
    sum = {1'b0, cur} + {{(ARITH_W-1){1'b0}}, inc};
    lim = (({{ARITH_W{1'b0}}, 1'b1}) << w) - 1'b1;
    if (sum > lim) return sat ? lim[ARITH_W-1:0] : (sum[ARITH_W-1:0] & lim[ARITH_W-1:0]);
    return sum[ARITH_W-1:0];
  endfunction

endpackage

// File: rtl/ds3_pm_events.sv
module ds3_pm_events
  import ds3_pm_pkg::*;
(
  input  logic              frame_stb,
  input  logic              cbit_mode,
  input  logic              fbit_err,
  input  logic              mbit_err,
  input  logic [NUM_P-1:0]  p_rx,
  input  logic              p_ref,
  input  logic [NUM_CP-1:0] cp_rx,
  input  logic              cp_ref,
  input  logic [NUM_FB-1:0] febe_rx,
  output logic [1:0]        fm_inc,
  output logic              ev_p,
  output logic              ev_cp,
  output logic              ev_febe
);
  always_comb begin
    fm_inc  = {1'b0, fbit_err} + {1'b0, mbit_err};
    ev_p    = frame_stb && p_mismatch(p_rx, p_ref);
    ev_cp   = frame_stb && cbit_mode && cp_vote(cp_rx, cp_ref);
    ev_febe = frame_stb && cbit_mode && febe_hit(febe_rx);
  end
endmodule

// File: rtl/ds3_pm_counter.sv
module ds3_pm_counter
  import ds3_pm_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         latch,
  input  logic         sat,
  input  logic [1:0]   inc,
  output logic [W-1:0] run,
  output logic [W-1:0] hold
);
  localparam int unsigned PADW = ARITH_W - W;

  logic [ARITH_W-1:0] nxt_wide;
  logic [W-1:0]       nxt;

  always_comb begin
    nxt_wide = pm_bump({{PADW{1'b0}}, run}, inc, W, sat);
    nxt      = nxt_wide[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= '0;
      hold <= '0;
    end else if (latch) begin
      hold <= run;
      run  <= W'(inc);
    end else begin
      run  <= nxt;
    end
  end
endmodule

// File: rtl/ds3_pm_bank.sv
module ds3_pm_bank
  import ds3_pm_pkg::*;
#(
  parameter int unsigned FM_W  = 12,
  parameter int unsigned CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sat_mode,
  input  logic              cbit_mode,
  input  logic              pm_latch,
  input  logic              frame_stb,
  input  logic              fbit_err,
  input  logic              mbit_err,
  input  logic [NUM_P-1:0]  p_rx,
  input  logic              p_ref,
  input  logic [NUM_CP-1:0] cp_rx,
  input  logic              cp_ref,
  input  logic [NUM_FB-1:0] febe_rx,
  output logic [FM_W-1:0]   hold_fm,
  output logic [CNT_W-1:0]  hold_p,
  output logic [CNT_W-1:0]  hold_cp,
  output logic [CNT_W-1:0]  hold_febe
);
  logic [1:0]       fm_inc;
  logic             ev_p, ev_cp, ev_febe;
  logic [FM_W-1:0]  run_fm;
  logic [CNT_W-1:0] run_p, run_cp, run_febe;

  ds3_pm_events u_ev (
    .frame_stb (frame_stb),
    .cbit_mode (cbit_mode),
    .fbit_err  (fbit_err),
    .mbit_err  (mbit_err),
    .p_rx      (p_rx),
    .p_ref     (p_ref),
    .cp_rx     (cp_rx),
    .cp_ref    (cp_ref),
    .febe_rx   (febe_rx),
    .fm_inc    (fm_inc),
    .ev_p      (ev_p),
    .ev_cp     (ev_cp),
    .ev_febe   (ev_febe)
  );

  ds3_pm_counter #(.W(FM_W)) u_fm (
    .clk(clk), .rst_n(rst_n), .latch(pm_latch), .sat(sat_mode),
    .inc(fm_inc), .run(run_fm), .hold(hold_fm)
  );

  ds3_pm_counter #(.W(CNT_W)) u_p (
    .clk(clk), .rst_n(rst_n), .latch(pm_latch), .sat(sat_mode),
    .inc({1'b0, ev_p}), .run(run_p), .hold(hold_p)
  );

  ds3_pm_counter #(.W(CNT_W)) u_cp (
    .clk(clk), .rst_n(rst_n), .latch(pm_latch), .sat(sat_mode),
    .inc({1'b0, ev_cp}), .run(run_cp), .hold(hold_cp)
  );

  ds3_pm_counter #(.W(CNT_W)) u_febe (
    .clk(clk), .rst_n(rst_n), .latch(pm_latch), .sat(sat_mode),
    .inc({1'b0, ev_febe}), .run(run_febe), .hold(hold_febe)
  );
endmodule

// File: rtl/ds3_pm_checker.sv
module ds3_pm_checker #(
  parameter int unsigned FM_W  = 12,
  parameter int unsigned CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pm_latch,
  input logic             sat_mode,
  input logic             cbit_mode,
  input logic [1:0]       fm_inc,
  input logic             ev_p,
  input logic             ev_cp,
  input logic             ev_febe,
  input logic [FM_W-1:0]  run_fm,
  input logic [CNT_W-1:0] run_p,
  input logic [FM_W-1:0]  hold_fm,
  input logic [CNT_W-1:0] hold_p,
  input logic [CNT_W-1:0] hold_cp,
  input logic [CNT_W-1:0] hold_febe
);
  localparam logic [FM_W-1:0] FM_MAX = '1;

  a_r5_cmode_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !cbit_mode |-> (!ev_cp && !ev_febe));

  a_r6_hold_takes_run: assert property (@(posedge clk) disable iff (!rst_n)
    pm_latch |=> (hold_fm == $past(run_fm) && hold_p == $past(run_p)));

  a_r7_restart_with_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pm_latch |=> (run_p == CNT_W'($past(ev_p)) && run_fm == FM_W'($past(fm_inc))));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_latch |=> ($stable(hold_fm) && $stable(hold_p) && $stable(hold_cp) && $stable(hold_febe)));

  a_r9_sat_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_mode && !pm_latch && run_fm == FM_MAX) |=> run_fm == FM_MAX);

  a_r1_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm_latch && fm_inc == 2'd0) |=> $stable(run_fm));
endmodule

bind ds3_pm_bank ds3_pm_checker #(.FM_W(FM_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pm_latch(pm_latch), .sat_mode(sat_mode),
  .cbit_mode(cbit_mode), .fm_inc(fm_inc), .ev_p(ev_p), .ev_cp(ev_cp),
  .ev_febe(ev_febe), .run_fm(run_fm), .run_p(run_p), .hold_fm(hold_fm),
  .hold_p(hold_p), .hold_cp(hold_cp), .hold_febe(hold_febe)
);

// File: tb/ds3_pm_bank_test.sv
`timescale 1ns/1ps
module ds3_pm_bank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sat_mode = 1'b0, cbit_mode = 1'b0, pm_latch = 1'b0, frame_stb = 1'b0;
  logic fbit_err = 1'b0, mbit_err = 1'b0, p_ref = 1'b0, cp_ref = 1'b0;
  logic [1:0] p_rx = '0;
  logic [2:0] cp_rx = '0;
  logic [2:0] febe_rx = 3'b111;
  logic [11:0] hold_fm;
  logic [13:0] hold_p, hold_cp, hold_febe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  typedef struct { int fm; int p; int cp; int febe; string tag; } exp_t;
  exp_t exp_q[$];
  exp_t last_exp;

  int m_fm = 0, m_p = 0, m_cp = 0, m_febe = 0;

  always #2.5 clk = ~clk;

  ds3_pm_bank uut (
    .clk(clk), .rst_n(rst_n), .sat_mode(sat_mode), .cbit_mode(cbit_mode),
    .pm_latch(pm_latch), .frame_stb(frame_stb), .fbit_err(fbit_err),
    .mbit_err(mbit_err), .p_rx(p_rx), .p_ref(p_ref), .cp_rx(cp_rx),
    .cp_ref(cp_ref), .febe_rx(febe_rx), .hold_fm(hold_fm), .hold_p(hold_p),
    .hold_cp(hold_cp), .hold_febe(hold_febe)
  );

  task automatic check(input string tag, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int model_next(input int cur, input int add, input int maxv);
    if (cur + add <= maxv) return cur + add;
    if (sat_mode) return maxv;
    return (cur + add) % (maxv + 1);
  endfunction

  // Driver: one cycle of stimulus, entered and left at a falling edge.
  task automatic step(input logic fb, input logic mb, input logic fs,
                      input logic [1:0] p, input logic pr,
                      input logic [2:0] c, input logic cr,
                      input logic [2:0] fe, input logic lat, input string tag);
    int a_fm, a_p, a_cp, a_fe, nd;
    exp_t e;
    fbit_err = fb; mbit_err = mb; frame_stb = fs; p_rx = p; p_ref = pr;
    cp_rx = c; cp_ref = cr; febe_rx = fe; pm_latch = lat;
    a_fm = int'(fb) + int'(mb);
    a_p  = (fs && p != {pr, pr}) ? 1 : 0;
    nd = 0;
    for (int i = 0; i < 3; i++) if (c[i] != cr) nd++;
    a_cp = (fs && cbit_mode && nd > 1) ? 1 : 0;
    a_fe = (fs && cbit_mode && fe != 3'b111) ? 1 : 0;
    if (lat) begin
      e.fm = m_fm; e.p = m_p; e.cp = m_cp; e.febe = m_febe; e.tag = tag;
      exp_q.push_back(e);
      m_fm = a_fm; m_p = a_p; m_cp = a_cp; m_febe = a_fe;
    end else begin
      m_fm   = model_next(m_fm, a_fm, 4095);
      m_p    = model_next(m_p, a_p, 16383);
      m_cp   = model_next(m_cp, a_cp, 16383);
      m_febe = model_next(m_febe, a_fe, 16383);
    end
    @(negedge clk);
    pm_latch = 1'b0; frame_stb = 1'b0; fbit_err = 1'b0; mbit_err = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 2'b00, 0, 3'b000, 0, 3'b111, 0, "idle");
  endtask

  task automatic latch_now(input string tag);
    step(0, 0, 0, 2'b00, 0, 3'b000, 0, 3'b111, 1, tag);
  endtask

  // Monitor: holds are due at the falling edge after the latch edge.
  initial begin
    logic lat;
    forever begin
      @(posedge clk);
      lat = pm_latch && rst_n;
      @(negedge clk);
      if (lat) begin
        if (exp_q.size() == 0) begin
          check("R6 queue empty", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          last_exp = e;
          check({e.tag, " fm"},   int'(hold_fm),   e.fm);
          check({e.tag, " p"},    int'(hold_p),    e.p);
          check({e.tag, " cp"},   int'(hold_cp),   e.cp);
          check({e.tag, " febe"}, int'(hold_febe), e.febe);
        end
      end
    end
  end

  task automatic check_stable(input string tag);
    check({tag, " fm"},   int'(hold_fm),   last_exp.fm);
    check({tag, " p"},    int'(hold_p),    last_exp.p);
    check({tag, " cp"},   int'(hold_cp),   last_exp.cp);
    check({tag, " febe"}, int'(hold_febe), last_exp.febe);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    last_exp = '{0, 0, 0, 0, ""};
    repeat (3) @(negedge clk);
    check("R11 reset fm", int'(hold_fm), 0);
    check("R11 reset p", int'(hold_p), 0);
    check("R11 reset cp", int'(hold_cp), 0);
    check("R11 reset febe", int'(hold_febe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    latch_now("R11 run zero after reset");
    idle(1);

    // R1 F/M errors, with and without frame strobe
    sat_mode = 1'b1; cbit_mode = 1'b1;
    step(1, 0, 0, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    step(0, 1, 1, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    step(1, 1, 0, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    // R2 P patterns: match, one off, match high, other off
    step(0, 0, 1, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    step(0, 0, 1, 2'b01, 0, 3'b000, 0, 3'b111, 0, "");
    step(0, 0, 1, 2'b11, 1, 3'b000, 0, 3'b111, 0, "");
    step(0, 0, 1, 2'b10, 1, 3'b000, 0, 3'b111, 0, "");
    step(0, 0, 0, 2'b01, 0, 3'b000, 0, 3'b111, 0, "");
    latch_now("R1 R2 fm p");
    idle(1);

    // R3 C-parity vote with 0,1,2,3 disagreements; R4 FEBE patterns
    step(0, 0, 1, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    step(0, 0, 1, 2'b00, 0, 3'b010, 0, 3'b111, 0, "");
    step(0, 0, 1, 2'b00, 0, 3'b101, 0, 3'b011, 0, "");
    step(0, 0, 1, 2'b00, 1, 3'b000, 1, 3'b000, 0, "");
    step(0, 0, 1, 2'b00, 0, 3'b110, 1, 3'b110, 0, "");
    latch_now("R3 R4 vote febe");
    idle(1);

    // R8 holds stay put while events arrive
    step(1, 1, 1, 2'b01, 0, 3'b111, 0, 3'b000, 0, "");
    check_stable("R8 stable a");
    step(1, 0, 1, 2'b10, 0, 3'b011, 0, 3'b001, 0, "");
    check_stable("R8 stable b");
    latch_now("R8 after stable window");
    idle(1);

    // R5 mode off: C-parity and FEBE inputs ignored
    cbit_mode = 1'b0;
    step(0, 0, 1, 2'b00, 0, 3'b111, 0, 3'b000, 0, "");
    step(0, 0, 1, 2'b00, 1, 3'b000, 0, 3'b010, 0, "");
    latch_now("R5 mode off");
    idle(1);
    cbit_mode = 1'b1;

    // R7 increments in the latch cycle join the new interval
    step(1, 0, 0, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    step(1, 1, 1, 2'b01, 0, 3'b011, 0, 3'b110, 1, "R7 latch with events");
    latch_now("R7 new interval");
    idle(1);

    // R9 saturation at 4095 on the F/M count
    sat_mode = 1'b1;
    for (int i = 0; i < 2047; i++) step(1, 1, 0, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    step(1, 1, 0, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    step(1, 0, 0, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    latch_now("R9 saturate");
    idle(1);

    // R10 wrap: 4094 + 2 -> 0, then +1
    sat_mode = 1'b0;
    for (int i = 0; i < 2047; i++) step(1, 1, 0, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    step(1, 1, 0, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    step(0, 1, 0, 2'b00, 0, 3'b000, 0, 3'b111, 0, "");
    latch_now("R10 wrap");
    idle(2);

    check("R6 queue drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule